// File: doc/BRIEF.md
# Frame-Indexed Operand Matcher

This block pairs the operands of dataflow instructions without any associative search. Each arriving token carries a frame pointer, an instruction pointer, a port bit and a data value. The instruction at that pointer is fetched first. It supplies an opcode, a dyadic flag, a slot offset and two destination descriptors. The slot address is the frame pointer plus the offset. A presence bit kept for every slot then decides the outcome. The first operand of a pair is parked in the slot. The second operand clears the bit, picks up the parked value and leaves the block as a matched pair for the execute stage.

There are four stages: instruction fetch, address generation, presence-bit update, and frame read or write. The frame memory and the instruction memory are held inside the block. A bench or a loader fills them through two write ports. Two tokens in a row that hit the same slot are resolved by forwarding the presence bit from the update stage into the address stage.

The instruction word is 19 bits. From the most significant bit down it holds: opcode (4), dyadic flag (1), slot offset (4), then destination 0 as enable (1), port (1) and delta (3), then destination 1 in the same layout.

Top module: `fdm_matcher`

## Requirements
- R1: After reset, `out_valid` is low and every presence bit is clear, so the first operand sent to any slot is parked.
- R2: A token is accepted on a rising edge while `tok_valid` is high. Its emission, if there is one, is on the outputs for one cycle after the third rising edge that follows.
- R3: The slot address is `tok_fp` plus the instruction's slot offset, modulo the frame depth (64 slots by default). Two tokens with different pointers that reach the same address therefore share one slot.
- R4: For a dyadic instruction (flag = 1) whose slot presence bit is clear, the bit is set, the value is stored and nothing is emitted.
- R5: For a dyadic instruction whose slot presence bit is set, the bit is cleared and one pair is emitted. The pair holds the stored value and the incoming value.
- R6: Operand order follows the incoming token's port. With port 0 the incoming value is `out_left` and the stored value is `out_right`. With port 1 the two are swapped.
- R7: A monadic instruction (flag = 0) is emitted without touching any presence bit. The value is on `out_left` and `out_right` is zero.
- R8: Tokens to the same slot on consecutive cycles alternate between park and match exactly as if they had been spaced apart.
- R9: Each emission carries the opcode and the frame pointer. For each destination it carries the enable bit, the port bit and the address `tok_ip + delta` modulo 2^IP_W. Destination 0 is bit/element 0 of the `out_dst_*` ports.
- R10: A write on the preload port sets a slot's value and presence bit. A write on the instruction port replaces the instruction word at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token present this cycle |
| tok_fp | input | AW (6) | Frame pointer |
| tok_ip | input | IP_W (5) | Instruction pointer |
| tok_port | input | 1 | 0 = left operand, 1 = right operand |
| tok_value | input | DW (16) | Operand value |
| imem_we | input | 1 | Instruction write enable |
| imem_addr | input | IP_W | Instruction write address |
| imem_wdata | input | 19 | Instruction word |
| fpre_we | input | 1 | Frame preload write enable |
| fpre_addr | input | AW | Frame slot to preload |
| fpre_value | input | DW | Preload value |
| fpre_present | input | 1 | Presence bit to preload |
| out_valid | output | 1 | Emission valid |
| out_opcode | output | 4 | Opcode of emitted instruction |
| out_left | output | DW | Left operand |
| out_right | output | DW | Right operand |
| out_fp | output | AW | Frame pointer of emission |
| out_dst_en | output | 2 | Destination enables |
| out_dst_port | output | 2 | Destination ports |
| out_dst_ip | output | 2 x IP_W | Destination instruction addresses |

## Verification
The assertions assume that the preload and instruction write ports are quiet while tokens are in flight. A preload into a slot that a pipelined token is touching would break the park/match sequence they check. The stimulus fills both memories only while the pipeline is empty, and it waits at least four idle cycles after the last token before any preload. The directed scenarios include same-slot tokens on consecutive cycles, interleaved pairs to neighbouring slots, address wrap at the frame and instruction boundaries, and cross-instruction slot sharing.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  parameter int OP_W  = 4;
  parameter int OFF_W = 4;
  parameter int DLT_W = 3;
  parameter int NDST  = 2;

  typedef struct packed {
    logic             en;
    logic             port;
    logic [DLT_W-1:0] delta;
  } dst_t;

  typedef struct packed {
    logic [OP_W-1:0]  opcode;
    logic             dyadic;
    logic [OFF_W-1:0] offset;
    dst_t [0:NDST-1]  dst;
  } instr_t;

  localparam int IW = $bits(instr_t);

  typedef enum logic [1:0] {K_PARK, K_MATCH, K_MONO} kind_e;
endpackage

// File: rtl/fdm_imem.sv
module fdm_imem #(
  parameter int AW = 5,
  parameter int W  = 19
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fdm_frame.sv
module fdm_frame #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [DW-1:0] pl_val,
  input  logic          pl_pres,
  input  logic [AW-1:0] pb_raddr,
  output logic          pb_rdata,
  input  logic          pb_we,
  input  logic [AW-1:0] pb_waddr,
  input  logic          pb_wbit,
  input  logic          fv_we,
  input  logic [AW-1:0] fv_addr,
  input  logic [DW-1:0] fv_wdata,
  output logic [DW-1:0] fv_rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DEPTH-1:0] pres;
  logic [DW-1:0]    val [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres <= '0;
    end else begin
      if (pb_we) pres[pb_waddr] <= pb_wbit;
      if (pl_we) pres[pl_addr]  <= pl_pres;
    end
  end

  always_ff @(posedge clk) begin
    if (fv_we) val[fv_addr] <= fv_wdata;
    if (pl_we) val[pl_addr] <= pl_val;
  end

  assign pb_rdata = pres[pb_raddr];
  assign fv_rdata = val[fv_addr];
endmodule

// File: rtl/fdm_matcher.sv
module fdm_matcher import fdm_pkg::*; #(
  parameter int DW   = 16,
  parameter int AW   = 6,
  parameter int IP_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tok_valid,
  input  logic [AW-1:0]              tok_fp,
  input  logic [IP_W-1:0]            tok_ip,
  input  logic                       tok_port,
  input  logic [DW-1:0]              tok_value,
  input  logic                       imem_we,
  input  logic [IP_W-1:0]            imem_addr,
  input  logic [IW-1:0]              imem_wdata,
  input  logic                       fpre_we,
  input  logic [AW-1:0]              fpre_addr,
  input  logic [DW-1:0]              fpre_value,
  input  logic                       fpre_present,
  output logic                       out_valid,
  output logic [OP_W-1:0]            out_opcode,
  output logic [DW-1:0]              out_left,
  output logic [DW-1:0]              out_right,
  output logic [AW-1:0]              out_fp,
  output logic [NDST-1:0]            out_dst_en,
  output logic [NDST-1:0]            out_dst_port,
  output logic [NDST-1:0][IP_W-1:0]  out_dst_ip
);
  // Arithmetic kept in functions so each rule is stated once
  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] fp,
                                              input logic [OFF_W-1:0] off);
    return fp + AW'(off);
  endfunction

  function automatic logic [IP_W-1:0] dest_ip(input logic [IP_W-1:0] ip,
                                              input logic [DLT_W-1:0] delta);
    return ip + IP_W'(delta);
  endfunction

  // returns {left, right}
  function automatic logic [2*DW-1:0] order_pair(input logic port,
                                                 input logic [DW-1:0] incoming,
                                                 input logic [DW-1:0] stored);
    return port ? {stored, incoming} : {incoming, stored};
  endfunction

  // ---------------- stage 1: instruction fetch ----------------
  logic [IW-1:0]   imem_rdata;
  instr_t          s1_ins;
  logic            s1_v, s1_port;
  logic [AW-1:0]   s1_fp;
  logic [IP_W-1:0] s1_ip;
  logic [DW-1:0]   s1_val;

  fdm_imem #(.AW(IP_W), .W(IW)) u_imem (
    .clk   (clk),
    .we    (imem_we),
    .waddr (imem_addr),
    .wdata (imem_wdata),
    .raddr (tok_ip),
    .rdata (imem_rdata)
  );

  assign s1_ins = instr_t'(imem_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_fp <= '0; s1_ip <= '0; s1_port <= 1'b0; s1_val <= '0;
    end else begin
      s1_v <= tok_valid;
      if (tok_valid) begin
        s1_fp <= tok_fp; s1_ip <= tok_ip; s1_port <= tok_port; s1_val <= tok_value;
      end
    end
  end

  // ---------------- stage 2: effective address ----------------
  logic            s2_v, s2_port, s2_dy, s2_pb;
  logic [AW-1:0]   s2_fp, s2_addr;
  logic [IP_W-1:0] s2_ip;
  logic [DW-1:0]   s2_val;
  logic [OP_W-1:0] s2_op;
  dst_t [0:NDST-1] s2_dst;

  logic [AW-1:0]   ea_addr;
  logic            pres_rd, ea_fwd, ea_pb, ea_same_slot;

  assign ea_addr      = slot_addr(s1_fp, s1_ins.offset);
  assign ea_fwd       = s2_v && s2_dy && (s2_addr == ea_addr);
  assign ea_pb        = ea_fwd ? ~s2_pb : pres_rd;
  assign ea_same_slot = s1_v && s1_ins.dyadic && ea_fwd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_port <= 1'b0; s2_dy <= 1'b0; s2_pb <= 1'b0;
      s2_fp <= '0; s2_addr <= '0; s2_ip <= '0; s2_val <= '0;
      s2_op <= '0; s2_dst <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_port <= s1_port; s2_dy <= s1_ins.dyadic; s2_pb <= ea_pb;
        s2_fp <= s1_fp; s2_addr <= ea_addr; s2_ip <= s1_ip; s2_val <= s1_val;
        s2_op <= s1_ins.opcode; s2_dst <= s1_ins.dst;
      end
    end
  end

  // ---------------- stage 3: presence-bit operation ----------------
  logic  pb_park, pb_match, pb_mono;
  kind_e pb_kind;

  assign pb_park  = s2_v && s2_dy && !s2_pb;
  assign pb_match = s2_v && s2_dy &&  s2_pb;
  assign pb_mono  = s2_v && !s2_dy;
  assign pb_kind  = !s2_dy ? K_MONO : (s2_pb ? K_MATCH : K_PARK);

  logic            s3_v, s3_port;
  kind_e           s3_kind;
  logic [AW-1:0]   s3_fp, s3_addr;
  logic [IP_W-1:0] s3_ip;
  logic [DW-1:0]   s3_val;
  logic [OP_W-1:0] s3_op;
  dst_t [0:NDST-1] s3_dst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s3_v <= 1'b0; s3_port <= 1'b0; s3_kind <= K_MONO;
      s3_fp <= '0; s3_addr <= '0; s3_ip <= '0; s3_val <= '0;
      s3_op <= '0; s3_dst <= '0;
    end else begin
      s3_v <= s2_v;
      if (s2_v) begin
        s3_port <= s2_port; s3_kind <= pb_kind;
        s3_fp <= s2_fp; s3_addr <= s2_addr; s3_ip <= s2_ip; s3_val <= s2_val;
        s3_op <= s2_op; s3_dst <= s2_dst;
      end
    end
  end

  // ---------------- stage 4: frame operation ----------------
  logic          fo_park, fo_emit;
  logic [DW-1:0] fo_stored;

  assign fo_park = s3_v && (s3_kind == K_PARK);
  assign fo_emit = s3_v && (s3_kind != K_PARK);

  fdm_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .pl_we    (fpre_we),
    .pl_addr  (fpre_addr),
    .pl_val   (fpre_value),
    .pl_pres  (fpre_present),
    .pb_raddr (ea_addr),
    .pb_rdata (pres_rd),
    .pb_we    (s2_v && s2_dy),
    .pb_waddr (s2_addr),
    .pb_wbit  (!s2_pb),
    .fv_we    (fo_park),
    .fv_addr  (s3_addr),
    .fv_wdata (s3_val),
    .fv_rdata (fo_stored)
  );

  logic [2*DW-1:0] fo_pair;
  assign fo_pair = (s3_kind == K_MONO) ? {s3_val, {DW{1'b0}}}
                                       : order_pair(s3_port, s3_val, fo_stored);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_opcode <= '0; out_left <= '0; out_right <= '0;
      out_fp <= '0;
    end else begin
      out_valid <= fo_emit;
      if (fo_emit) begin
        out_opcode <= s3_op;
        {out_left, out_right} <= fo_pair;
        out_fp <= s3_fp;
      end
    end
  end

  for (genvar g = 0; g < NDST; g++) begin : g_dst
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_dst_en[g] <= 1'b0; out_dst_port[g] <= 1'b0; out_dst_ip[g] <= '0;
      end else if (fo_emit) begin
        out_dst_en[g]   <= s3_dst[g].en;
        out_dst_port[g] <= s3_dst[g].port;
        out_dst_ip[g]   <= dest_ip(s3_ip, s3_dst[g].delta);
      end
    end
  end
endmodule

// File: rtl/fdm_matcher_chk.sv
module fdm_matcher_chk (
  input logic clk,
  input logic rst_n,
  input logic out_valid,
  input logic pb_park,
  input logic pb_match,
  input logic pb_mono,
  input logic ea_same_slot
);
  // R4: a parked operand produces no emission
  p_park_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pb_park |-> ##2 !out_valid);

  // R5: a match produces an emission
  p_match_emits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pb_match |-> ##2 out_valid);

  // R7: a monadic instruction always emits
  p_mono_emits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pb_mono |-> ##2 out_valid);

  // R8: same-slot follower after a park must match
  p_fwd_park_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_park && ea_same_slot) |=> pb_match);

  // R8: same-slot follower after a match must park
  p_fwd_match_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_match && ea_same_slot) |=> pb_park);
endmodule

bind fdm_matcher fdm_matcher_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .out_valid    (out_valid),
  .pb_park      (pb_park),
  .pb_match     (pb_match),
  .pb_mono      (pb_mono),
  .ea_same_slot (ea_same_slot)
);

// File: tb/fdm_matcher_tb.sv
module fdm_matcher_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             tok_valid = 0, tok_port = 0;
  logic [5:0]       tok_fp = 0;
  logic [4:0]       tok_ip = 0;
  logic [15:0]      tok_value = 0;
  logic             imem_we = 0;
  logic [4:0]       imem_addr = 0;
  logic [18:0]      imem_wdata = 0;
  logic             fpre_we = 0, fpre_present = 0;
  logic [5:0]       fpre_addr = 0;
  logic [15:0]      fpre_value = 0;
  logic             out_valid;
  logic [3:0]       out_opcode;
  logic [15:0]      out_left, out_right;
  logic [5:0]       out_fp;
  logic [1:0]       out_dst_en, out_dst_port;
  logic [1:0][4:0]  out_dst_ip;

  fdm_matcher u_dut (.*);

  int n_chk = 0, n_bad = 0;
  int cap_n = 0;
  logic [15:0] cap_l [64], cap_r [64];
  logic [3:0]  cap_op [64];
  logic [5:0]  cap_fp [64];
  logic [1:0]  cap_en [64], cap_pt [64];
  logic [4:0]  cap_d0 [64], cap_d1 [64];

  always @(negedge clk) if (rst_n && out_valid && cap_n < 64) begin
    cap_l[cap_n] = out_left;  cap_r[cap_n] = out_right; cap_op[cap_n] = out_opcode;
    cap_fp[cap_n] = out_fp;   cap_en[cap_n] = out_dst_en; cap_pt[cap_n] = out_dst_port;
    cap_d0[cap_n] = out_dst_ip[0]; cap_d1[cap_n] = out_dst_ip[1];
    cap_n++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] mk(input logic [3:0] op, input logic dy, input logic [3:0] off,
      input logic e0, input logic p0, input logic [2:0] d0,
      input logic e1, input logic p1, input logic [2:0] d1);
    return {op, dy, off, e0, p0, d0, e1, p1, d1};
  endfunction

  task automatic load_ins(input logic [4:0] a, input logic [18:0] w);
    @(negedge clk); imem_we = 1; imem_addr = a; imem_wdata = w;
    @(negedge clk); imem_we = 0;
  endtask

  task automatic preload(input logic [5:0] a, input logic [15:0] v, input logic p);
    @(negedge clk); fpre_we = 1; fpre_addr = a; fpre_value = v; fpre_present = p;
    @(negedge clk); fpre_we = 0;
  endtask

  // drives one token for exactly one cycle; consecutive calls are back-to-back
  task automatic send(input logic [5:0] fp, input logic [4:0] ip, input logic pt,
                      input logic [15:0] v);
    tok_valid = 1; tok_fp = fp; tok_ip = ip; tok_port = pt; tok_value = v;
    @(negedge clk); tok_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pair(input string req, input int i, input logic [15:0] l,
                             input logic [15:0] r, input logic [3:0] op);
    check({req, " left"}, cap_l[i], l);
    check({req, " right"}, cap_r[i], r);
    check({req, " opcode"}, cap_op[i], op);
  endtask

  // R1: quiet after reset, first operand parks
  task automatic t_reset;
    check("R1 out_valid", out_valid, 0);
    check("R1 no emission", cap_n, 0);
    send(6'd1, 5'd8, 1'b0, 16'h0abc); idle(6);
    check("R1 fresh slot parks", cap_n, 0);
    send(6'd1, 5'd8, 1'b1, 16'h0def); idle(6);
    check("R1 pair count", cap_n, 1);
    expect_pair("R1", 0, 16'h0abc, 16'h0def, 4'h9);
  endtask

  // R2, R7, R9: exact latency and monadic fields
  task automatic t_mono;
    int b = cap_n;
    tok_valid = 1; tok_fp = 6'd5; tok_ip = 5'd3; tok_port = 1; tok_value = 16'h1357;
    @(posedge clk);
    @(negedge clk); tok_valid = 0;
    check("R2 not yet (edge+0)", out_valid, 0);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R2 not yet (edge+2)", out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    check("R2 valid at edge+3", out_valid, 1);
    idle(3);
    check("R7 single emission", cap_n, b + 1);
    expect_pair("R7", b, 16'h1357, 16'h0000, 4'h5);
    check("R9 fp", cap_fp[b], 6'd5);
    check("R9 dst en", cap_en[b], 2'b01);
    check("R9 dst port", cap_pt[b], 2'b01);
    check("R9 dst0 ip", cap_d0[b], 5'd4);
    // R7: slot 5 presence untouched, so a dyadic token there parks
    send(6'd5, 5'd10, 1'b0, 16'h2222); idle(6);
    check("R7 presence untouched", cap_n, b + 1);
    send(6'd5, 5'd10, 1'b1, 16'h3333); idle(6);
    expect_pair("R7 later pair", b + 1, 16'h2222, 16'h3333, 4'h2);
  endtask

  // R4, R5, R6, R9: both arrival orders
  task automatic t_pairs;
    int b = cap_n;
    send(6'd4, 5'd8, 1'b0, 16'h1111); idle(6);
    check("R4 park no emission", cap_n, b);
    send(6'd4, 5'd8, 1'b1, 16'h2222); idle(6);
    check("R5 one emission", cap_n, b + 1);
    expect_pair("R5", b, 16'h1111, 16'h2222, 4'h9);
    check("R9 dst0 ip", cap_d0[b], 5'd10);
    check("R9 dst1 ip", cap_d1[b], 5'd13);
    check("R9 dst port", cap_pt[b], 2'b10);
    check("R9 dst en", cap_en[b], 2'b11);
    send(6'd20, 5'd8, 1'b1, 16'haaaa); idle(3);
    send(6'd20, 5'd8, 1'b0, 16'h5555); idle(6);
    expect_pair("R6 right first", b + 1, 16'h5555, 16'haaaa, 4'h9);
  endtask

  // R3, R9: address sum, slot sharing and wrap
  task automatic t_addr;
    int b = cap_n;
    send(6'd6, 5'd8, 1'b0, 16'h0101); idle(4);
    send(6'd8, 5'd10, 1'b1, 16'h0202); idle(6);
    expect_pair("R3 shared slot", b, 16'h0101, 16'h0202, 4'h2);
    send(6'd60, 5'd30, 1'b0, 16'h7777); idle(4);
    send(6'd60, 5'd30, 1'b1, 16'h6666); idle(6);
    expect_pair("R3 wrap pair", b + 1, 16'h7777, 16'h6666, 4'hc);
    check("R9 ip wrap", cap_d0[b + 1], 5'd1);
    send(6'd60, 5'd30, 1'b0, 16'h1234); idle(4);
    send(6'd11, 5'd10, 1'b1, 16'h4321); idle(6);
    expect_pair("R3 wrapped slot shared", b + 2, 16'h1234, 16'h4321, 4'h2);
  endtask

  // R8: back-to-back tokens on one slot and interleaved slots
  task automatic t_b2b;
    int b = cap_n;
    send(6'd30, 5'd8, 1'b0, 16'h0001);
    send(6'd30, 5'd8, 1'b1, 16'h0002);
    send(6'd30, 5'd8, 1'b0, 16'h0003);
    send(6'd30, 5'd8, 1'b1, 16'h0004);
    idle(6);
    check("R8 two emissions", cap_n, b + 2);
    expect_pair("R8 first", b, 16'h0001, 16'h0002, 4'h9);
    expect_pair("R8 second", b + 1, 16'h0003, 16'h0004, 4'h9);
    send(6'd30, 5'd8, 1'b0, 16'h0005); idle(6);
    check("R8 slot left clear", cap_n, b + 2);
    send(6'd30, 5'd8, 1'b1, 16'h0006); idle(6);
    expect_pair("R8 after", b + 2, 16'h0005, 16'h0006, 4'h9);
    send(6'd40, 5'd8, 1'b0, 16'h00a0);
    send(6'd41, 5'd8, 1'b0, 16'h00b0);
    send(6'd40, 5'd8, 1'b1, 16'h00c0);
    send(6'd41, 5'd8, 1'b1, 16'h00d0);
    idle(6);
    expect_pair("R8 interleave a", b + 3, 16'h00a0, 16'h00c0, 4'h9);
    expect_pair("R8 interleave b", b + 4, 16'h00b0, 16'h00d0, 4'h9);
  endtask

  // R10: preloaded slots
  task automatic t_preload;
    int b = cap_n;
    preload(6'd50, 16'hbeef, 1'b1);
    send(6'd48, 5'd8, 1'b1, 16'h0f0f); idle(6);
    expect_pair("R10 preloaded match", b, 16'hbeef, 16'h0f0f, 4'h9);
    preload(6'd51, 16'hdead, 1'b0);
    send(6'd49, 5'd8, 1'b0, 16'h0303); idle(6);
    check("R10 preload clear parks", cap_n, b + 1);
    load_ins(5'd8, mk(4'h6, 1'b0, 4'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0));
    send(6'd2, 5'd8, 1'b0, 16'h4444); idle(6);
    expect_pair("R10 instruction rewrite", b + 1, 16'h4444, 16'h0000, 4'h6);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    load_ins(5'd3,  mk(4'h5, 1'b0, 4'd0,  1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 3'd0));
    load_ins(5'd8,  mk(4'h9, 1'b1, 4'd2,  1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 3'd5));
    load_ins(5'd10, mk(4'h2, 1'b1, 4'd0,  1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 3'd0));
    load_ins(5'd30, mk(4'hc, 1'b1, 4'd15, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 3'd0));
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_mono();
    t_pairs();
    t_addr();
    t_b2b();
    t_preload();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule